// File: doc/BRIEF.md
# Codec Frame Sync Slave Timing Generator

This block produces the frame timing for a serial codec port when the external codec is the timing master. The codec supplies the bit clock, which clocks this block on its rising edge, and the frame sync line `fsync`. The block samples `fsync` on each edge and decides when a frame begins. It then counts bits within each word and words within the frame. A separate data shifter uses the strobes and indices it outputs to move the serial data. The block holds no data itself.

Three framing styles share one sync detector:
- **Level start.** A high sample begins a frame. This is the multichannel style.
- **Either edge.** A change between two samples begins a frame. This is the I2S style.
- **Tag slot first.** A high sample begins a frame whose first slot is a fixed 16-bit tag slot. The data slots that follow use the programmed word size. This is the AC-link style.

In the level and tag styles, a frame always runs to its programmed length once it has begun, and sync pulses that arrive during it are ignored. The one exception is the frame's final bit, when a new sync chains the next frame directly. In the either-edge style, every edge restarts the counters.

Top module: `cfs_slave_timing`

## Requirements
- R1: When `rst` is high or `en` is low at a clock edge, the block is idle in the following cycle. In that state `frame_busy`, `word_start` and `frame_start` are 0, and `slot_idx` and `bit_idx` are 0. The sampled sync history is also cleared.
- R2: With `mode` = 0 (level start), suppose `fsync` is sampled high at edge k while the block is idle. The frame then starts at edge k+1. In the cycle after edge k+1, `frame_busy`, `word_start` and `frame_start` are all 1, and `slot_idx` = `bit_idx` = 0.
- R3: With `mode` = 1 (either edge), suppose the samples at edges k-1 and k differ, and both edges fell after the block left the idle state. The frame then restarts at edge k+1 with both counters cleared, even in the middle of a frame.
- R4: With `mode` = 2 (tag slot first), a frame starts as in R2. Slot 0 lasts 16 bits whatever the word size. Every later slot uses the programmed word size.
- R5: A word lasts max(`wsize_m1`, 3) + 1 bits. `bit_idx` counts 0, 1, … up to the word's last bit. `word_start` is 1 exactly when `frame_busy` is 1 and `bit_idx` is 0.
- R6: A frame holds `wpf_m1` + 1 slots, with `slot_idx` counting from 0. `frame_busy` falls in the cycle after the last bit of the last slot, and both indices then return to 0.
- R7: In modes 0, 2 and 3, a high sync sample during a frame is ignored. The exception is a high sample at the frame's last bit, which starts the next frame at once with no idle cycle between the two frames.
- R8: Mode 3 behaves exactly as mode 0.
- R9: `frame_start` is 1 only in the cycle of bit 0 of slot 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec bit clock; the block acts on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; when low, the block is held idle |
| mode | input | 2 | Framing style: 0 level, 1 either edge, 2 tag slot, 3 same as 0 |
| wsize_m1 | input | 4 | Word length in bits minus one (values below 3 act as 3) |
| wpf_m1 | input | 4 | Words per frame minus one |
| fsync | input | 1 | Frame sync from the codec |
| word_start | output | 1 | High on bit 0 of every word |
| frame_start | output | 1 | High on bit 0 of slot 0 |
| slot_idx | output | 4 | Index of the current word within the frame |
| bit_idx | output | 4 | Index of the current bit within the word |
| frame_busy | output | 1 | High while a frame is in progress |

## Verification
The bench uses the default parameters: 4-bit bit and slot counters, a 16-bit tag slot and a 4-bit minimum word. These settings let it run a 16-word frame of 16-bit words and a tag slot that fills the whole bit counter. They also put the word-size clamp and a one-word frame within the same short run. Each mode is driven with held-high sync, single pulses and toggling sync. These patterns place pulses inside a frame, on its last bit and in the middle of a word. An enable drop mid-frame shows the return to idle.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    FS_LEVEL  = 2'd0,
    FS_EDGE   = 2'd1,
    FS_TAG    = 2'd2,
    FS_LEVEL2 = 2'd3
  } fs_mode_e;
endpackage

// File: rtl/cfs_sync_detect.sv
module cfs_sync_detect (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fsync,
  output logic level_hit,
  output logic edge_hit
);
  logic       samp_now;
  logic       samp_prev;
  logic [1:0] hist_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      samp_now  <= 1'b0;
      samp_prev <= 1'b0;
      hist_cnt  <= 2'd0;
    end else begin
      samp_now  <= fsync;
      samp_prev <= samp_now;
      if (hist_cnt != 2'd2) hist_cnt <= hist_cnt + 2'd1;
    end
  end

  // a level start needs one sample, an edge needs two valid samples
  assign level_hit = samp_now && (hist_cnt != 2'd0);
  assign edge_hit  = (hist_cnt == 2'd2) && (samp_now ^ samp_prev);
endmodule

// File: rtl/cfs_frame_count.sv
module cfs_frame_count #(
  parameter int CNT_W   = 4,
  parameter int SLOT_W  = 4,
  parameter int TAG_LEN = 16,
  parameter int MIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              accept,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  wsize_m1,
  input  logic [SLOT_W-1:0] wpf_m1,
  output logic              busy,
  output logic [CNT_W-1:0]  bit_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              word_end,
  output logic              frame_last
);
  import cfs_pkg::*;

  localparam logic [CNT_W-1:0] TAG_LAST = CNT_W'(TAG_LEN - 1);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_LEN - 1);

  function automatic logic [CNT_W-1:0] last_bit_of(
    input logic [1:0]        md,
    input logic [SLOT_W-1:0] sl,
    input logic [CNT_W-1:0]  wm1
  );
    if (md == FS_TAG && sl == '0) return TAG_LAST;
    else if (wm1 < MIN_LAST)      return MIN_LAST;
    else                          return wm1;
  endfunction

  logic [CNT_W-1:0] word_last;

  assign word_last  = last_bit_of(mode, slot_idx, wsize_m1);
  assign word_end   = busy && (bit_idx == word_last);
  assign frame_last = word_end && (slot_idx == wpf_m1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy     <= 1'b0;
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (busy) begin
      if (word_end) begin
        bit_idx <= '0;
        if (slot_idx == wpf_m1) begin
          busy     <= 1'b0;
          slot_idx <= '0;
        end else begin
          slot_idx <= slot_idx + 1'b1;
        end
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfs_slave_timing.sv
module cfs_slave_timing #(
  parameter int CNT_W   = 4,
  parameter int SLOT_W  = 4,
  parameter int TAG_LEN = 16,
  parameter int MIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  wsize_m1,
  input  logic [SLOT_W-1:0] wpf_m1,
  input  logic              fsync,
  output logic              word_start,
  output logic              frame_start,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [CNT_W-1:0]  bit_idx,
  output logic              frame_busy
);
  import cfs_pkg::*;

  logic level_hit;
  logic edge_hit;
  logic is_edge_mode;
  logic sync_hit;
  logic accept;
  logic word_end;
  logic frame_last;

  cfs_sync_detect u_detect (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .fsync     (fsync),
    .level_hit (level_hit),
    .edge_hit  (edge_hit)
  );

  assign is_edge_mode = (mode == FS_EDGE);
  assign sync_hit     = is_edge_mode ? edge_hit : level_hit;
  // edges always restart; level syncs wait for the frame's last bit
  assign accept = en && sync_hit && (is_edge_mode || !frame_busy || frame_last);

  cfs_frame_count #(
    .CNT_W   (CNT_W),
    .SLOT_W  (SLOT_W),
    .TAG_LEN (TAG_LEN),
    .MIN_LEN (MIN_LEN)
  ) u_count (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .accept     (accept),
    .mode       (mode),
    .wsize_m1   (wsize_m1),
    .wpf_m1     (wpf_m1),
    .busy       (frame_busy),
    .bit_idx    (bit_idx),
    .slot_idx   (slot_idx),
    .word_end   (word_end),
    .frame_last (frame_last)
  );

  assign word_start  = frame_busy && (bit_idx == '0);
  assign frame_start = word_start && (slot_idx == '0);
endmodule

// File: rtl/cfs_slave_timing_chk.sv
module cfs_slave_timing_chk #(
  parameter int CNT_W  = 4,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [1:0]        mode,
  input logic [SLOT_W-1:0] wpf_m1,
  input logic              edge_hit,
  input logic              accept,
  input logic              word_end,
  input logic              frame_last,
  input logic              frame_start,
  input logic              frame_busy,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [CNT_W-1:0]  bit_idx
);
  assert_idle_after_stop_R1: assert property (@(posedge clk)
    (rst || !en) |=> (!frame_busy && slot_idx == '0 && bit_idx == '0));

  assert_start_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && en) |=> (frame_start && frame_busy));

  assert_edge_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'd1 && edge_hit) |=> frame_start);

  assert_bit_steps_R5: assert property (@(posedge clk) disable iff (rst)
    (en && frame_busy && !word_end && !accept) |=>
      (!en || bit_idx == CNT_W'($past(bit_idx) + 1'b1)));

  assert_busy_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (en && frame_last && !accept) |=> !frame_busy);

  assert_slot_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    frame_busy |-> (slot_idx <= wpf_m1));

  assert_sync_locked_out_R7: assert property (@(posedge clk) disable iff (rst)
    (en && mode != 2'd1 && frame_busy && !frame_last) |=> !frame_start);
endmodule

bind cfs_slave_timing cfs_slave_timing_chk #(
  .CNT_W  (CNT_W),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .mode        (mode),
  .wpf_m1      (wpf_m1),
  .edge_hit    (edge_hit),
  .accept      (accept),
  .word_end    (word_end),
  .frame_last  (frame_last),
  .frame_start (frame_start),
  .frame_busy  (frame_busy),
  .slot_idx    (slot_idx),
  .bit_idx     (bit_idx)
);

// File: tb/test_cfs_slave_timing.sv
module test_cfs_slave_timing;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] wsize_m1 = 4'd3;
  logic [3:0] wpf_m1 = 4'd2;
  logic       fsync = 1'b0;
  logic       word_start, frame_start, frame_busy;
  logic [3:0] slot_idx, bit_idx;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    chk_on = 1'b0;
  string phase = "R1 reset";

  // behavioural reference state
  int m_now = 0, m_prev = 0, m_hist = 0;
  int m_busy = 0, m_bit = 0, m_slot = 0;

  always #4 clk = ~clk;

  cfs_slave_timing i_cfs_slave_timing (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .wsize_m1(wsize_m1),
    .wpf_m1(wpf_m1), .fsync(fsync), .word_start(word_start),
    .frame_start(frame_start), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .frame_busy(frame_busy)
  );

  always @(posedge clk) begin
    int  lb;
    bit  last, hit, take, edge_mode;
    cycles++;
    if (rst || !en) begin
      m_now = 0; m_prev = 0; m_hist = 0;
      m_busy = 0; m_bit = 0; m_slot = 0;
    end else begin
      edge_mode = (mode == 2'd1);
      if (mode == 2'd2 && m_slot == 0) lb = 15;
      else lb = (wsize_m1 < 3) ? 3 : int'(wsize_m1);
      last = (m_busy != 0) && (m_bit == lb) && (m_slot == int'(wpf_m1));
      hit  = edge_mode ? (m_hist >= 2 && m_now != m_prev) : (m_hist >= 1 && m_now != 0);
      take = hit && (edge_mode || m_busy == 0 || last);
      if (take) begin
        m_busy = 1; m_bit = 0; m_slot = 0;
      end else if (m_busy != 0) begin
        if (m_bit == lb) begin
          m_bit = 0;
          if (m_slot == int'(wpf_m1)) begin m_busy = 0; m_slot = 0; end
          else m_slot++;
        end else m_bit++;
      end
      m_prev = m_now;
      m_now  = fsync ? 1 : 0;
      if (m_hist < 2) m_hist++;
    end
  end

  task automatic compare();
    logic [10:0] act, exp;
    bit ws;
    ws  = (m_busy != 0) && (m_bit == 0);
    exp = {ws, ws && (m_slot == 0), 4'(m_slot), 4'(m_bit), (m_busy != 0)};
    act = {word_start, frame_start, slot_idx, bit_idx, frame_busy};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", phase, cycles, act, exp);
    end
  endtask

  // apply inputs for the next edge, then check at the falling edge after it
  task automatic tick(input logic fs);
    fsync = fs;
    @(negedge clk);
    if (chk_on) compare();
  endtask

  task automatic run(input logic fs, input int n);
    for (int i = 0; i < n; i++) tick(fs);
  endtask

  task automatic configure(input string p, input logic [1:0] md,
                           input logic [3:0] ws, input logic [3:0] wp);
    phase = p;
    rst = 1'b1; mode = md; wsize_m1 = ws; wpf_m1 = wp;
    run(1'b0, 2);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    chk_on = 1'b1;
    // R1: reset state
    configure("R1 reset", 2'd0, 4'd3, 4'd2);
    run(1'b0, 3);
    // R2 R5 R6 R9: single pulse, 4-bit words, 3 slots
    configure("R2 R5 R6 R9 level pulse", 2'd0, 4'd3, 4'd2);
    run(1'b0, 2); tick(1'b1); run(1'b0, 20);
    // R7: pulses inside a frame, then held high for back-to-back frames
    configure("R7 lockout", 2'd0, 4'd4, 4'd1);
    tick(1'b1); run(1'b0, 3); tick(1'b1); run(1'b0, 2); tick(1'b1);
    run(1'b0, 8); run(1'b1, 30); run(1'b0, 12);
    // R3: either-edge restarts mid-word and mid-frame
    configure("R3 edge mode", 2'd1, 4'd7, 4'd1);
    run(1'b1, 5); run(1'b0, 5); run(1'b1, 3); run(1'b0, 20); run(1'b1, 20);
    // R4: tag slot of 16 bits then 12-bit slots
    configure("R4 tag slot", 2'd2, 4'd11, 4'd2);
    tick(1'b1); run(1'b0, 45); run(1'b1, 50); run(1'b0, 10);
    // R5: word size clamp, single-word frame
    configure("R5 clamp", 2'd0, 4'd1, 4'd0);
    tick(1'b1); run(1'b0, 6); run(1'b1, 12); run(1'b0, 6);
    // R8: alternate level code
    configure("R8 mode 3", 2'd3, 4'd5, 4'd1);
    run(1'b1, 20); run(1'b0, 10);
    // R1: enable drop mid-frame
    configure("R1 disable", 2'd0, 4'd3, 4'd3);
    tick(1'b1); run(1'b0, 5);
    en = 1'b0; run(1'b1, 2); en = 1'b1; run(1'b0, 6); tick(1'b1); run(1'b0, 20);
    // R6: largest frame
    configure("R6 max frame", 2'd0, 4'd15, 4'd15);
    tick(1'b1); run(1'b0, 262);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule